// File: doc/BRIEF.md
# Three-State Phase-Frequency Detector

This block compares the rising edges of a reference stream and a feedback stream, both sampled on a fast system clock. It commands a charge-pump style loop through a pull-up enable, a pull-down enable and one resolved three-state pin. The pin drives high to raise the oscillator frequency, drives low to lower it, and floats so that the loop filter holds its voltage. A lock output is high whenever neither driver is active.

Internally the detector works as a saturating up/down counter with three states: neutral, pumping up and pumping down. A qualified reference edge counts up and a qualified feedback edge counts down. Only rising edges count, so the duty factor of either input has no effect. With no reference edges present, the feedback edges keep the pull-down active, which pushes the oscillator toward its lowest frequency. A synchronous inhibit input forces the detector to neutral and keeps it there.

Top module: `pfd_tristate`

## Requirements
- R1: While and after reset, up_en_o and dn_en_o are 0 and lock_o is 1.
- R2: From neutral, a rising edge on ref_i alone asserts up_en_o on the clock edge SYNC_STAGES cycles after the edge that first samples ref_i high.
- R3: From neutral, a rising edge on fb_i alone asserts dn_en_o with the same latency. With ref_i held low, repeated fb_i edges keep dn_en_o asserted.
- R4: In the pumping-up state a feedback edge returns the detector to neutral, not to pumping down. In the pumping-down state a reference edge returns it to neutral.
- R5: The count saturates. Repeated edges on the same input while already pumping in that direction leave the state unchanged, so one opposite edge is enough to return to neutral.
- R6: When a reference edge and a feedback edge are qualified in the same clock cycle, the next state is neutral.
- R7: Falling edges and steady levels on ref_i and fb_i never change the state.
- R8: up_en_o and dn_en_o are never 1 in the same cycle.
- R9: pump_o is 1 while up_en_o is 1, 0 while dn_en_o is 1, and high-impedance otherwise.
- R10: lock_o is 1 exactly when both up_en_o and dn_en_o are 0.
- R11: hold_i sampled high at a clock edge makes the state neutral after that edge. Edges qualified while hold_i is high are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than twice either input rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_i | input | 1 | Synchronous inhibit, forces and keeps neutral |
| ref_i | input | 1 | Asynchronous reference stream |
| fb_i | input | 1 | Asynchronous feedback stream |
| up_en_o | output | 1 | Pull-up driver enable |
| dn_en_o | output | 1 | Pull-down driver enable |
| pump_o | output | 1 | Resolved three-state drive pin |
| lock_o | output | 1 | High while both drivers are off |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default of 2. This makes the generate-built chain longer and moves the input-to-output latency to three cycles, so a design that hard-wires a two-flop path misses the latency checks. Random streams with unequal edge rates drive the detector into sustained pumping in either direction, and directed cases line up same-cycle edges, falling edges and inhibit windows.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        PFD_IDLE = 2'd0,
        PFD_UP   = 2'd1,
        PFD_DN   = 2'd2
    } pfd_state_e;

    typedef struct packed {
        pfd_state_e st;
    } pfd_core_regs_t;

    localparam int PFD_NUM_INPUTS = 2;
    localparam int PFD_REF_IDX    = 0;
    localparam int PFD_FB_IDX     = 1;

endpackage

// File: rtl/pfd_edge_detect.sv
module pfd_edge_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } regs_t;

    regs_t d, q;

    always_comb begin
        d       = q;
        d.chain = {q.chain[LAST-1:0], sig_i};
        d.prev  = q.chain[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // a new high at the end of the chain, low one sample earlier
    assign rise_o = q.chain[LAST] & ~q.prev;

endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold_i,
    input  logic       ref_rise_i,
    input  logic       fb_rise_i,
    output pfd_state_e state_o
);
    pfd_core_regs_t d, q;

    always_comb begin
        d = q;
        if (hold_i) begin
            d.st = PFD_IDLE;
        end else if (ref_rise_i && fb_rise_i) begin
            d.st = PFD_IDLE;
        end else if (ref_rise_i) begin
            d.st = (q.st == PFD_DN) ? PFD_IDLE : PFD_UP;
        end else if (fb_rise_i) begin
            d.st = (q.st == PFD_UP) ? PFD_IDLE : PFD_DN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: PFD_IDLE};
        else        q <= d;
    end

    assign state_o = q.st;

endmodule

// File: rtl/pfd_drive.sv
module pfd_drive
    import pfd_pkg::*;
(
    input  pfd_state_e state_i,
    output logic       up_en_o,
    output logic       dn_en_o,
    output logic       lock_o,
    output logic       pump_o
);
    always_comb begin
        up_en_o = 1'b0;
        dn_en_o = 1'b0;
        unique case (state_i)
            PFD_UP:  up_en_o = 1'b1;
            PFD_DN:  dn_en_o = 1'b1;
            default: ;
        endcase
    end

    assign lock_o = (state_i != PFD_UP) && (state_i != PFD_DN);
    assign pump_o = (state_i == PFD_UP) ? 1'b1 :
                    (state_i == PFD_DN) ? 1'b0 : 1'bz;

endmodule

// File: rtl/pfd_tristate.sv
module pfd_tristate
    import pfd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic ref_i,
    input  logic fb_i,
    output logic up_en_o,
    output logic dn_en_o,
    output logic pump_o,
    output logic lock_o
);
    logic [PFD_NUM_INPUTS-1:0] raw;
    logic [PFD_NUM_INPUTS-1:0] rise;
    pfd_state_e                state;

    assign raw[PFD_REF_IDX] = ref_i;
    assign raw[PFD_FB_IDX]  = fb_i;

    for (genvar g = 0; g < PFD_NUM_INPUTS; g++) begin : g_edge
        pfd_edge_detect #(.STAGES(SYNC_STAGES)) edge_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .sig_i  (raw[g]),
            .rise_o (rise[g])
        );
    end

    pfd_core core_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_i     (hold_i),
        .ref_rise_i (rise[PFD_REF_IDX]),
        .fb_rise_i  (rise[PFD_FB_IDX]),
        .state_o    (state)
    );

    pfd_drive drive_i (
        .state_i (state),
        .up_en_o (up_en_o),
        .dn_en_o (dn_en_o),
        .lock_o  (lock_o),
        .pump_o  (pump_o)
    );

endmodule

// File: rtl/pfd_tristate_chk.sv
module pfd_tristate_chk #(
    parameter int SYNC_STAGES = 2
) (
    input logic clk,
    input logic rst_n,
    input logic hold_i,
    input logic ref_i,
    input logic fb_i,
    input logic up_en_o,
    input logic dn_en_o,
    input logic pump_o,
    input logic lock_o
);
    localparam int HLEN = SYNC_STAGES + 2;

    logic [HLEN-1:0] ref_h, fb_h;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_h <= '0;
            fb_h  <= '0;
        end else begin
            ref_h <= {ref_h[HLEN-2:0], ref_i};
            fb_h  <= {fb_h[HLEN-2:0], fb_i};
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |-> !up_en_o && !dn_en_o && lock_o); // R1
    AST_UP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up_en_o) |-> ref_h[SYNC_STAGES] && !ref_h[SYNC_STAGES+1]); // R2
    AST_DN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn_en_o) |-> fb_h[SYNC_STAGES] && !fb_h[SYNC_STAGES+1]); // R3
    AST_UP_NO_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        up_en_o |=> !dn_en_o); // R4
    AST_DN_NO_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        dn_en_o |=> !up_en_o); // R4
    AST_NO_DUAL_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_en_o && dn_en_o)); // R8
    AST_PUMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        up_en_o |-> pump_o == 1'b1); // R9
    AST_PUMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        dn_en_o |-> pump_o == 1'b0); // R9
    AST_LOCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o == (!up_en_o && !dn_en_o)); // R10
    AST_HOLD_NEUTRAL: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> !up_en_o && !dn_en_o); // R11

endmodule

bind pfd_tristate pfd_tristate_chk #(.SYNC_STAGES(SYNC_STAGES)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold_i  (hold_i),
    .ref_i   (ref_i),
    .fb_i    (fb_i),
    .up_en_o (up_en_o),
    .dn_en_o (dn_en_o),
    .pump_o  (pump_o),
    .lock_o  (lock_o)
);

// File: tb/pfd_tristate_tb_top.sv
`timescale 1ns/1ps
module pfd_tristate_tb_top;
    localparam int SYNC = 3;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_i = 1'b0;
    logic ref_i = 1'b0;
    logic fb_i = 1'b0;
    logic up_en_o, dn_en_o, pump_o, lock_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int ms      = 0;          // model: 0 neutral, 1 up, 2 down
    bit rh [1:SYNC+1];        // rh[j] = ref_i sampled j edges ago
    bit fh [1:SYNC+1];

    always #2.5 clk = ~clk;

    pfd_tristate #(.SYNC_STAGES(SYNC)) dut_i (
        .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .ref_i(ref_i), .fb_i(fb_i),
        .up_en_o(up_en_o), .dn_en_o(dn_en_o), .pump_o(pump_o), .lock_o(lock_o)
    );

    function automatic int next_state(int s, bit rr, bit fr, bit h);
        if (h) return 0;
        if (rr && fr) return 0;
        if (rr) return (s == 2) ? 0 : 1;
        if (fr) return (s == 1) ? 0 : 2;
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare(input string req);
        check(up_en_o === (ms == 1), req, "up_en_o", int'(up_en_o), int'(ms == 1));
        check(dn_en_o === (ms == 2), req, "dn_en_o", int'(dn_en_o), int'(ms == 2));
        check(lock_o === (ms == 0), "R10", "lock_o", int'(lock_o), int'(ms == 0));
        check(!(up_en_o && dn_en_o), "R8", "up&dn", int'(up_en_o && dn_en_o), 0);
        if (ms == 1) check(pump_o === 1'b1, "R9", "pump_o", int'(pump_o), 1);
        if (ms == 2) check(pump_o === 1'b0, "R9", "pump_o", int'(pump_o), 0);
    endtask

    task automatic step(input bit r, input bit f, input bit h, input string req);
        bit rr, fr;
        ref_i = r; fb_i = f; hold_i = h;
        @(posedge clk);
        rr = rh[SYNC] & ~rh[SYNC+1];
        fr = fh[SYNC] & ~fh[SYNC+1];
        ms = next_state(ms, rr, fr, h);
        for (int j = SYNC + 1; j >= 2; j--) begin
            rh[j] = rh[j-1];
            fh[j] = fh[j-1];
        end
        rh[1] = r;
        fh[1] = f;
        @(negedge clk);
        compare(req);
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) step(ref_i, fb_i, 1'b0, req);
    endtask

    task automatic pulse(input bit r, input bit f, input string req);
        step(r | ref_i, f | fb_i, 1'b0, req);
        step(r | ref_i, f | fb_i, 1'b0, req);
        step(r ? 1'b0 : ref_i, f ? 1'b0 : fb_i, 1'b0, req);
        step(ref_i, fb_i, 1'b0, req);
    endtask

    task automatic random_run(input int cycles, input int rdiv, input int fdiv, input int hdiv);
        int rc = 0, fc = 0;
        bit r, f, h;
        for (int i = 0; i < cycles; i++) begin
            r = ref_i; f = fb_i;
            rc++; fc++;
            if (rc >= 2 && ($urandom % rdiv) == 0) begin r = ~r; rc = 0; end
            if (fc >= 2 && ($urandom % fdiv) == 0) begin f = ~f; fc = 0; end
            h = (hdiv != 0) && (($urandom % hdiv) == 0);
            step(r, f, h, "R2/R3");
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual %0d expected <= %0d cycles", cyc, WATCHDOG);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        for (int j = 1; j <= SYNC + 1; j++) begin rh[j] = 1'b0; fh[j] = 1'b0; end
        repeat (3) @(negedge clk);
        // R1: during reset
        check(up_en_o === 1'b0 && dn_en_o === 1'b0, "R1", "enables in reset", int'(up_en_o | dn_en_o), 0);
        check(lock_o === 1'b1, "R1", "lock in reset", int'(lock_o), 1);
        rst_n = 1'b1;
        idle(4, "R1");

        // R2: reference edge from neutral, exact latency
        step(1'b1, 1'b0, 1'b0, "R2");
        for (int i = 0; i < SYNC - 1; i++) step(1'b1, 1'b0, 1'b0, "R2");
        check(up_en_o === 1'b0, "R2", "up too early", int'(up_en_o), 0);
        step(1'b1, 1'b0, 1'b0, "R2");
        check(up_en_o === 1'b1, "R2", "up at latency", int'(up_en_o), 1);

        // R7: falling edge and steady level do nothing
        step(1'b0, 1'b0, 1'b0, "R7");
        idle(6, "R7");
        check(up_en_o === 1'b1, "R7", "up after ref fall", int'(up_en_o), 1);

        // R5: second reference edge saturates, one feedback edge returns to neutral
        pulse(1'b1, 1'b0, "R5");
        idle(SYNC + 2, "R5");
        pulse(1'b0, 1'b1, "R5");
        idle(SYNC + 2, "R5");
        check(lock_o === 1'b1 && dn_en_o === 1'b0, "R5", "neutral after one fb edge", int'(dn_en_o), 0);

        // R3: feedback edges with no reference keep pull-down
        for (int k = 0; k < 4; k++) begin
            pulse(1'b0, 1'b1, "R3");
            idle(2, "R3");
        end
        check(dn_en_o === 1'b1, "R3", "dn with no reference", int'(dn_en_o), 1);

        // R4: reference edge while pumping down -> neutral
        pulse(1'b1, 1'b0, "R4");
        idle(SYNC + 2, "R4");
        check(lock_o === 1'b1 && up_en_o === 1'b0, "R4", "neutral from down", int'(up_en_o), 0);
        pulse(1'b1, 1'b0, "R4");
        idle(SYNC + 2, "R4");
        pulse(1'b0, 1'b1, "R4");
        idle(SYNC + 2, "R4");
        check(lock_o === 1'b1 && dn_en_o === 1'b0, "R4", "neutral from up", int'(dn_en_o), 0);

        // R6: simultaneous edges from up and from neutral
        pulse(1'b1, 1'b0, "R6");
        idle(SYNC + 2, "R6");
        pulse(1'b1, 1'b1, "R6");
        idle(SYNC + 2, "R6");
        check(lock_o === 1'b1, "R6", "neutral after same-cycle edges", int'(lock_o), 1);

        // R11: inhibit clears and swallows edges
        pulse(1'b1, 1'b0, "R11");
        idle(SYNC + 2, "R11");
        step(ref_i, fb_i, 1'b1, "R11");
        check(up_en_o === 1'b0 && lock_o === 1'b1, "R11", "hold clears", int'(up_en_o), 0);
        step(1'b1, fb_i, 1'b1, "R11");
        for (int i = 0; i < SYNC + 3; i++) step(1'b1, fb_i, 1'b1, "R11");
        step(1'b0, fb_i, 1'b0, "R11");
        idle(SYNC + 2, "R11");
        check(up_en_o === 1'b0, "R11", "edge during hold discarded", int'(up_en_o), 0);

        // random phases: reference faster, feedback faster, equal, with inhibit
        random_run(3000, 3, 9, 0);
        random_run(3000, 9, 3, 0);
        random_run(3000, 4, 4, 0);
        random_run(3000, 3, 5, 40);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule